// File: doc/BRIEF.md
# Feed-Protected Clock Configuration Registers

This block is a register bank that controls a clock-multiplier unit. Software writes a multiplier, a divider and two control bits (enable and connect) into staging registers over a simple 32-bit register bus. A staged value does nothing on its own. Only a two-write unlock sequence to a dedicated key register moves the staged values into the live registers that drive the clock unit. A spurious write therefore cannot retune or switch the system clock.

A status register reads back the live values, never the staged ones, together with a lock flag that an external lock detector drives. The connect bit goes live only when the live enable is set and lock is already reported. This keeps the system from switching onto a clock that has not settled.

Top module: `clkcfg_regbank`

## Requirements
- R1: Address bits 3:2 select the register: 0 = control (read/write, reads return the staged value), 1 = configuration (read/write, reads return the staged value), 2 = status (read-only), 3 = key (write-only). Address bits 1:0 are ignored.
- R2: A write to control or configuration changes no output and no status field until a valid key sequence completes.
- R3: A valid key sequence copies the staged enable, multiplier and divider to the live outputs on the clock edge that accepts its second write. Status reads show the new values from the next cycle on.
- R4: A valid key sequence is a key write with bits 7:0 = 0xAA, followed by a key write with bits 7:0 = 0x55 as the next bus access. Any other access in between aborts the sequence: a read of any register, a write to another register, or a key write of another value. Idle cycles between the two writes do not abort it. A repeated 0xAA arms the sequence again.
- R5: The live connect bit is committed as staged connect AND staged enable AND lock_in, sampled at the commit edge.
- R6: Control uses bit 0 for enable and bit 1 for connect. Configuration holds multiplier minus one in bits 14:0 and divider minus one in bits 23:16. Writes to other bit positions are ignored, and those positions read as zero.
- R7: Status packs the live multiplier at bits 14:0, the live divider at bits 23:16, the live enable at bit 24, the live connect at bit 25 and the current lock_in at bit 26. All other bits read as zero.
- R8: After reset, the staged and live registers are zero. Key reads return zero, and bus_rdata is zero in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| lock_in | input | 1 | Lock indication from the clock unit |
| pll_en | output | 1 | Live enable |
| pll_conn | output | 1 | Live connect |
| pll_mul | output | 15 | Live multiplier minus one |
| pll_div | output | 8 | Live divider minus one |

## Verification
A wrong key-sequence state shows at the ports in two ways: a commit that should have happened does not, or a commit happens that should not. Either one changes the live outputs within one cycle of the second key write. A staging register that leaks to the outputs changes pll_* on the edge after the control or configuration write, and a wrongly gated connect shows on pll_conn the cycle after the commit. The bench compares all live outputs with its own model every cycle, and every read against the same model, so a divergence is caught in the cycle it appears.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int DATA_W      = 32;
  localparam int MUL_W       = 15;
  localparam int DIV_W       = 8;
  localparam int DIV_LSB     = 16;
  localparam int ST_EN_BIT   = 24;
  localparam int ST_CONN_BIT = 25;
  localparam int ST_LOCK_BIT = 26;
  localparam int KEY_W       = 8;
  localparam logic [KEY_W-1:0] KEY_ARM    = 8'hAA;
  localparam logic [KEY_W-1:0] KEY_COMMIT = 8'h55;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic             conn;
    logic [MUL_W-1:0] mul;
    logic [DIV_W-1:0] div;
  } clk_set_t;

  function automatic logic [DATA_W-1:0] pack_ctrl(clk_set_t s);
    logic [DATA_W-1:0] v;
    v = '0;
    v[0] = s.en;
    v[1] = s.conn;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(clk_set_t s);
    logic [DATA_W-1:0] v;
    v = '0;
    v[MUL_W-1:0] = s.mul;
    v[DIV_LSB +: DIV_W] = s.div;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(clk_set_t s, logic lock);
    logic [DATA_W-1:0] v;
    v = pack_cfg(s);
    v[ST_EN_BIT]   = s.en;
    v[ST_CONN_BIT] = s.conn;
    v[ST_LOCK_BIT] = lock;
    return v;
  endfunction

  function automatic clk_set_t gate_commit(clk_set_t held, logic lock);
    clk_set_t s;
    s = held;
    s.conn = held.conn & held.en & lock;
    return s;
  endfunction
endpackage

// File: rtl/clkcfg_staging.sv
module clkcfg_staging
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wdata,
  output clk_set_t          held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else begin
      if (wr_ctrl) begin
        held.en   <= wdata[0];
        held.conn <= wdata[1];
      end
      if (wr_cfg) begin
        held.mul <= wdata[MUL_W-1:0];
        held.div <= wdata[DIV_LSB +: DIV_W];
      end
    end
  end
endmodule

// File: rtl/clkcfg_key_seq.sv
module clkcfg_key_seq
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  output logic             armed,
  output logic             commit
);
  logic key_is_arm, key_is_commit;

  assign key_is_arm    = key_wr && (key == KEY_ARM);
  assign key_is_commit = key_wr && (key == KEY_COMMIT);
  assign commit        = armed && key_is_commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (access) armed <= key_is_arm;
  end

  // R4: an idle cycle leaves the sequence state alone
  p_idle_keeps_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> $stable(armed));
endmodule

// File: rtl/clkcfg_live.sv
module clkcfg_live
  import clkcfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  clk_set_t held,
  input  logic     lock_in,
  output clk_set_t live
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else if (commit) live <= gate_commit(held, lock_in);
  end

  p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live));

  p_live_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live.mul == $past(held.mul)) && (live.div == $past(held.div))
               && (live.en == $past(held.en)));

  p_conn_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!live.conn || (live.en && $past(lock_in))));
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lock_in,
  output logic              pll_en,
  output logic              pll_conn,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [DIV_W-1:0]  pll_div
);
  reg_sel_e sel;
  logic     wr_ctrl, wr_cfg, key_wr, access, armed, commit;
  clk_set_t held, live;

  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_cfg  = bus_wr && (sel == SEL_CFG);
  assign key_wr  = bus_wr && (sel == SEL_KEY);
  assign access  = bus_wr || bus_rd;

  clkcfg_staging u_staging (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
    .wdata(bus_wdata), .held(held)
  );

  clkcfg_key_seq u_key_seq (
    .clk(clk), .rst_n(rst_n), .access(access), .key_wr(key_wr),
    .key(bus_wdata[KEY_W-1:0]), .armed(armed), .commit(commit)
  );

  clkcfg_live u_live (
    .clk(clk), .rst_n(rst_n), .commit(commit), .held(held),
    .lock_in(lock_in), .live(live)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_CTRL: bus_rdata = pack_ctrl(held);
        SEL_CFG:  bus_rdata = pack_cfg(held);
        SEL_STAT: bus_rdata = pack_status(live, lock_in);
        SEL_KEY:  bus_rdata = '0;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pll_en   = live.en;
  assign pll_conn = live.conn;
  assign pll_mul  = live.mul;
  assign pll_div  = live.div;

  p_stat_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_STAT) |-> (bus_rdata[DATA_W-1:ST_LOCK_BIT+1] == '0)
                                    && (bus_rdata[ST_LOCK_BIT] == lock_in));

  p_key_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_KEY) |-> (bus_rdata == '0));

  p_no_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_clkcfg_regbank.sv
module test_clkcfg_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lock_in = 1'b0;
  logic        pll_en, pll_conn;
  logic [14:0] pll_mul;
  logic [7:0]  pll_div;

  int n_checks = 0, n_fail = 0;

  // bench model
  bit        m_hen, m_hconn, m_len, m_lconn, m_armed;
  bit [14:0] m_hmul, m_lmul;
  bit [7:0]  m_hdiv, m_ldiv;

  always #5 clk = ~clk;

  clkcfg_regbank i_clkcfg_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lock_in(lock_in), .pll_en(pll_en), .pll_conn(pll_conn),
    .pll_mul(pll_mul), .pll_div(pll_div)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a, input bit lk);
    case (a[3:2])
      2'd0: return 32'(m_hconn) * 2 + 32'(m_hen);
      2'd1: return (32'(m_hdiv) << 16) | 32'(m_hmul);
      2'd2: return (32'(lk) << 26) | (32'(m_lconn) << 25) | (32'(m_len) << 24)
                   | (32'(m_ldiv) << 16) | 32'(m_lmul);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_live(input string req);
    chk(req, {31'b0, pll_en}, {31'b0, m_len});
    chk(req, {31'b0, pll_conn}, {31'b0, m_lconn});
    chk(req, {17'b0, pll_mul}, {17'b0, m_lmul});
    chk(req, {24'b0, pll_div}, {24'b0, m_ldiv});
  endtask

  task automatic model_edge(input bit w, input bit r, input logic [3:0] a,
                            input logic [31:0] d, input bit lk);
    if (w && a[3:2] == 2'd0) begin m_hen = d[0]; m_hconn = d[1]; end
    if (w && a[3:2] == 2'd1) begin m_hmul = d[14:0]; m_hdiv = d[23:16]; end
    if (w || r) begin
      if (m_armed && w && a[3:2] == 2'd3 && d[7:0] == 8'h55) begin
        m_len = m_hen; m_lmul = m_hmul; m_ldiv = m_hdiv;
        m_lconn = m_hen && m_hconn && lk;
      end
      m_armed = w && a[3:2] == 2'd3 && d[7:0] == 8'hAA;
    end
  endtask

  // one bus cycle: check live outputs, drive, check read data, clock, update model
  task automatic cyc(input bit w, input bit r, input logic [3:0] a,
                     input logic [31:0] d, input bit lk, input string req);
    @(negedge clk);
    check_live({"R2 R3 live ", req});
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; lock_in = lk;
    #1;
    if (r) chk({"R1 R7 read ", req}, bus_rdata, exp_read(a, lk));
    else   chk("R8 idle rdata", bus_rdata, 32'h0);
    @(posedge clk);
    model_edge(w, r, a, d, lk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit lk, input string req);
    cyc(1'b1, 1'b0, a, d, lk, req);
  endtask
  task automatic rd(input logic [3:0] a, input bit lk, input string req);
    cyc(1'b0, 1'b1, a, 32'h0, lk, req);
  endtask
  task automatic idle(input bit lk);
    cyc(1'b0, 1'b0, 4'h0, 32'h0, lk, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 reset state
    rd(4'h0, 1'b0, "R8 ctrl reset");
    rd(4'h4, 1'b0, "R8 cfg reset");
    rd(4'h8, 1'b0, "R8 status reset");
    rd(4'hC, 1'b0, "R8 key reads zero");
    chk("R8 reset live", {pll_en, pll_conn, 15'(pll_mul), 8'(pll_div)}, 32'h0);

    // R2: staged values are invisible without the key sequence; R6 unused bits
    wr(4'h4, 32'hFF12_8123, 1'b1, "R6 cfg write");
    wr(4'h0, 32'hFFFF_FFFF, 1'b1, "R6 ctrl write");
    rd(4'h4, 1'b1, "R6 cfg staged readback");
    chk("R6 cfg masked", exp_read(4'h4, 1'b1), 32'h0012_0123);
    rd(4'h8, 1'b1, "R2 status before key");
    idle(1'b1);
    chk("R2 outputs unchanged", {31'b0, pll_en}, 32'h0);

    // R4: a read between the two key writes aborts
    wr(4'hC, 32'hAA, 1'b1, "R4 arm");
    rd(4'h0, 1'b1, "R4 intervening read");
    wr(4'hC, 32'h55, 1'b1, "R4 aborted commit");
    idle(1'b1);
    chk("R4 abort keeps live", {17'b0, pll_mul}, 32'h0);

    // R3 R4: idle cycles between key writes are allowed; commit with lock high
    wr(4'hC, 32'hAA, 1'b1, "R4 arm");
    idle(1'b1); idle(1'b1);
    wr(4'hD, 32'hFFFF_FF55, 1'b1, "R3 commit, R1 low address bits");
    rd(4'h8, 1'b1, "R3 status after commit");
    chk("R3 committed mul", {17'b0, pll_mul}, 32'h0123);
    chk("R5 conn with lock", {31'b0, pll_conn}, 32'h1);

    // R5: connect is dropped when lock is low at commit
    wr(4'hC, 32'hAA, 1'b0, "R4 arm");
    wr(4'hC, 32'hAA, 1'b0, "R4 re-arm");
    wr(4'hC, 32'h55, 1'b0, "R5 commit lock low");
    idle(1'b1);
    chk("R5 conn without lock", {31'b0, pll_conn}, 32'h0);
    chk("R5 enable still set", {31'b0, pll_en}, 32'h1);

    // R5: connect without enable is dropped
    wr(4'h0, 32'h2, 1'b1, "R5 conn only");
    wr(4'hC, 32'hAA, 1'b1, "R4 arm");
    wr(4'hC, 32'h55, 1'b1, "R5 commit no enable");
    idle(1'b1);
    chk("R5 conn needs enable", {30'b0, pll_conn, pll_en}, 32'h0);

    // R4: a wrong key value aborts
    wr(4'h4, 32'h0007_0042, 1'b1, "R4 new cfg");
    wr(4'hC, 32'hAA, 1'b1, "R4 arm");
    wr(4'hC, 32'h56, 1'b1, "R4 wrong key");
    wr(4'hC, 32'h55, 1'b1, "R4 late commit");
    idle(1'b1);
    chk("R4 wrong key no commit", {24'b0, pll_div}, 32'h12);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      bit lk;
      logic [31:0] d;
      op = $urandom % 12;
      lk = ($urandom % 4) != 0;
      d  = $urandom;
      case (op)
        0, 1:    wr(4'h0 | 4'($urandom % 4), d, lk, "rand ctrl");
        2:       wr(4'h4, d, lk, "rand cfg");
        3, 4, 5: wr(4'hC, 32'hAA | (d & 32'hFFFF_FF00), lk, "R4 rand arm");
        6, 7:    wr(4'hC, 32'h55, lk, "R3 rand commit");
        8:       wr(4'hC, d, lk, "R4 rand key");
        9:       rd(4'($urandom % 16), lk, "rand read");
        default: idle(lk);
      endcase
    end
    idle(1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule